// File: doc/BRIEF.md
# DRAM Read/Write Bus Turnaround Arbiter

This block decides when a memory controller's shared data bus is handed between read traffic and write draining. It watches the occupancy of the read and write queues, a drain request, and one strobe per burst issued in each direction. From these it keeps a bus mode. In write mode, read scheduling is held off. On leaving write mode, it holds a write-to-read turnaround stall before reads are granted again.

Entry into write mode happens in two cases: the write queue reaches a high watermark, or a drain is requested while writes are pending. Write mode is re-examined after every write burst. It ends when one of three conditions holds. The first is that the write queue is empty. The second is that the queue has fallen far enough below a low watermark, with the minimum-writes-per-switch value used as the hysteresis margin, and no drain is active. The third is that reads are waiting and enough writes have been served since the last switch. Both watermarks are computed from the write buffer depth and a percentage.

The block counts the bursts served in each direction. At every turnaround it presents the count for the direction being left on a one-cycle sample pulse for a statistics sampler, then clears that count. The sample outputs are plain strobes with no back-pressure. A turnaround cannot be delayed, so the sampler must accept a pulse in any cycle.

Top module: `rw_turn_arbiter`

## Requirements
- R1: The high watermark is floor(WR_BUF*HI_PCT/100) and the low watermark is floor(WR_BUF*LO_PCT/100). With the defaults (WR_BUF=32, HI_PCT=75, LO_PCT=50) these are 24 and 16.
- R2: In read mode, on any clock edge where wr_q_occ >= high watermark, or where drain_req=1 and wr_q_occ != 0, write_mode becomes 1 after that edge.
- R3: While write_mode=1, rd_grant is 0. On a cycle without wr_burst, write mode is kept.
- R4: In write mode, a cycle with wr_burst=1 and wr_q_occ=0 returns the block to read mode after that edge. wr_q_occ is the occupancy remaining after that burst.
- R5: In write mode, a cycle with wr_burst=1, drain_req=0 and wr_q_occ+MIN_WR < low watermark returns the block to read mode. With drain_req=1 this condition does not apply.
- R6: In write mode, a cycle with wr_burst=1, rd_q_occ != 0, and a write count of at least MIN_WR (the count includes the current burst) returns the block to read mode.
- R7: The edge that returns the block to read mode loads a stall of TWTR cycles. bus_stall=1 and rd_grant=0 for exactly TWTR cycles, and rd_grant then rises unless write mode was re-entered.
- R8: The read count adds one per cycle with rd_burst=1, and the write count adds one per cycle with wr_burst=1, in either mode.
- R9: On entering write mode, rd_smp_valid pulses for one cycle with the read count, which includes a burst in the switching cycle, and the read count is cleared. On leaving write mode, wr_smp_valid pulses in the same way with the write count.
- R10: The read count saturates at RD_BUF and the write count saturates at WR_BUF, so no sample exceeds its buffer depth.
- R11: Reset (rst_n=0, asynchronous) gives read mode: write_mode=0, rd_grant=1, bus_stall=0, no sample pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_q_occ | input | $clog2(RD_BUF+1) | Read queue occupancy |
| wr_q_occ | input | $clog2(WR_BUF+1) | Write queue occupancy (after any burst this cycle) |
| drain_req | input | 1 | Request to empty the write queue |
| rd_burst | input | 1 | One read burst issued this cycle |
| wr_burst | input | 1 | One write burst issued this cycle |
| write_mode | output | 1 | Bus is draining writes; read scheduling stopped |
| rd_grant | output | 1 | Reads may be scheduled |
| bus_stall | output | 1 | Write-to-read turnaround in progress |
| rd_smp_valid | output | 1 | Read-count sample pulse |
| rd_smp_count | output | $clog2(RD_BUF+1) | Reads served before the switch to writes |
| wr_smp_valid | output | 1 | Write-count sample pulse |
| wr_smp_count | output | $clog2(WR_BUF+1) | Writes served before the switch to reads |

## Verification
Several properties are checked on every cycle. Write mode is entered only for a watermark or drain cause. Write mode is held on cycles without a write burst. Every entry and exit of write mode produces the matching sample pulse, and no pulse appears otherwise. Every exit starts a turnaround stall with the read grant low. Samples never exceed their depths. Which exit condition fires, the exact watermark boundaries, the hysteresis edge at occupancy+MIN_WR equal to the low watermark, the drain override, the stall length and the counter saturation can only be shown by the bench scenarios and by its per-cycle comparison against a behavioural model.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
  typedef enum logic { MODE_READ = 1'b0, MODE_WRITE = 1'b1 } rw_mode_e;

  function automatic int unsigned pct_of(input int unsigned depth, input int unsigned pct);
    return (depth * pct) / 100;
  endfunction
endpackage

// File: rtl/rwt_burst_counter.sv
module rwt_burst_counter #(
  parameter int unsigned MAXV = 16,
  parameter int unsigned W    = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         take,
  output logic [W-1:0] cnt_next,
  output logic         smp_valid,
  output logic [W-1:0] smp_count
);
  localparam logic [W-1:0] MAXV_W = W'(MAXV);

  logic [W-1:0] cnt_q;

  // saturating increment: the sample range stays within the buffer depth
  always_comb begin
    cnt_next = cnt_q;
    if (inc && (cnt_q < MAXV_W)) cnt_next = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      smp_valid <= 1'b0;
      smp_count <= '0;
    end else if (take) begin
      smp_count <= cnt_next;
      smp_valid <= 1'b1;
      cnt_q     <= '0;
    end else begin
      cnt_q     <= cnt_next;
      smp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rwt_switch_policy.sv
module rwt_switch_policy
  import rwt_pkg::*;
#(
  parameter int unsigned WR_BUF = 32,
  parameter int unsigned HI_PCT = 75,
  parameter int unsigned LO_PCT = 50,
  parameter int unsigned MIN_WR = 4,
  parameter int unsigned RDW    = 5,
  parameter int unsigned WRW    = 6
) (
  input  logic           in_write,
  input  logic [RDW-1:0] rd_q_occ,
  input  logic [WRW-1:0] wr_q_occ,
  input  logic           drain_req,
  input  logic           wr_burst,
  input  logic [WRW-1:0] wr_cnt_next,
  output logic           enter_write,
  output logic           leave_write
);
  localparam int unsigned HI_THR = pct_of(WR_BUF, HI_PCT);
  localparam int unsigned LO_THR = pct_of(WR_BUF, LO_PCT);

  logic [31:0] occ32;
  logic [31:0] cnt32;
  logic        hi_hit, drain_hit;
  logic        q_empty, below_hyst, reads_wait;

  assign occ32 = 32'(wr_q_occ);
  assign cnt32 = 32'(wr_cnt_next);

  // read -> write causes
  assign hi_hit    = occ32 >= 32'(HI_THR);
  assign drain_hit = drain_req && (wr_q_occ != '0);

  // write -> read causes, examined after each write burst
  assign q_empty    = (wr_q_occ == '0);
  assign below_hyst = ((occ32 + 32'(MIN_WR)) < 32'(LO_THR)) && !drain_req;
  assign reads_wait = (rd_q_occ != '0) && (cnt32 >= 32'(MIN_WR));

  assign enter_write = !in_write && (hi_hit || drain_hit);
  assign leave_write = in_write && wr_burst && (q_empty || below_hyst || reads_wait);
endmodule

// File: rtl/rwt_turn_stall.sv
module rwt_turn_stall #(
  parameter int unsigned TWTR = 3,
  parameter int unsigned W    = $clog2(TWTR + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam logic [W-1:0] TWTR_W = W'(TWTR);

  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (load)            left_q <= TWTR_W;
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/rw_turn_arbiter.sv
module rw_turn_arbiter
  import rwt_pkg::*;
#(
  parameter  int unsigned RD_BUF = 16,
  parameter  int unsigned WR_BUF = 32,
  parameter  int unsigned HI_PCT = 75,
  parameter  int unsigned LO_PCT = 50,
  parameter  int unsigned MIN_WR = 4,
  parameter  int unsigned TWTR   = 3,
  localparam int unsigned RDW    = $clog2(RD_BUF + 1),
  localparam int unsigned WRW    = $clog2(WR_BUF + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RDW-1:0] rd_q_occ,
  input  logic [WRW-1:0] wr_q_occ,
  input  logic           drain_req,
  input  logic           rd_burst,
  input  logic           wr_burst,
  output logic           write_mode,
  output logic           rd_grant,
  output logic           bus_stall,
  output logic           rd_smp_valid,
  output logic [RDW-1:0] rd_smp_count,
  output logic           wr_smp_valid,
  output logic [WRW-1:0] wr_smp_count
);
  generate
    if (TWTR < 1) begin : g_bad_twtr
      $error("TWTR must be at least one cycle");
    end
    if (pct_of(WR_BUF, HI_PCT) <= pct_of(WR_BUF, LO_PCT)) begin : g_bad_thr
      $error("high watermark must exceed low watermark");
    end
  endgenerate

  rw_mode_e       mode_q;
  logic           enter_write, leave_write;
  logic [RDW-1:0] rd_cnt_next;
  logic [WRW-1:0] wr_cnt_next;

  rwt_switch_policy #(
    .WR_BUF(WR_BUF), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT),
    .MIN_WR(MIN_WR), .RDW(RDW), .WRW(WRW)
  ) policy_i (
    .in_write   (mode_q == MODE_WRITE),
    .rd_q_occ   (rd_q_occ),
    .wr_q_occ   (wr_q_occ),
    .drain_req  (drain_req),
    .wr_burst   (wr_burst),
    .wr_cnt_next(wr_cnt_next),
    .enter_write(enter_write),
    .leave_write(leave_write)
  );

  rwt_burst_counter #(.MAXV(RD_BUF), .W(RDW)) rd_cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(rd_burst), .take(enter_write),
    .cnt_next(rd_cnt_next), .smp_valid(rd_smp_valid), .smp_count(rd_smp_count)
  );

  rwt_burst_counter #(.MAXV(WR_BUF), .W(WRW)) wr_cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(wr_burst), .take(leave_write),
    .cnt_next(wr_cnt_next), .smp_valid(wr_smp_valid), .smp_count(wr_smp_count)
  );

  rwt_turn_stall #(.TWTR(TWTR)) stall_i (
    .clk(clk), .rst_n(rst_n), .load(leave_write), .busy(bus_stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= MODE_READ;
    else if (enter_write) mode_q <= MODE_WRITE;
    else if (leave_write) mode_q <= MODE_READ;
  end

  assign write_mode = (mode_q == MODE_WRITE);
  assign rd_grant   = !write_mode && !bus_stall;

  logic unused_rd_next;
  assign unused_rd_next = ^rd_cnt_next;
endmodule

// File: rtl/rwt_checker.sv
module rwt_checker #(
  parameter  int unsigned RD_BUF = 16,
  parameter  int unsigned WR_BUF = 32,
  parameter  int unsigned HI_PCT = 75,
  localparam int unsigned RDW    = $clog2(RD_BUF + 1),
  localparam int unsigned WRW    = $clog2(WR_BUF + 1),
  localparam int unsigned HI_THR = (WR_BUF * HI_PCT) / 100
) (
  input logic           clk,
  input logic           rst_n,
  input logic [RDW-1:0] rd_q_occ,
  input logic [WRW-1:0] wr_q_occ,
  input logic           drain_req,
  input logic           rd_burst,
  input logic           wr_burst,
  input logic           write_mode,
  input logic           rd_grant,
  input logic           bus_stall,
  input logic           rd_smp_valid,
  input logic [RDW-1:0] rd_smp_count,
  input logic           wr_smp_valid,
  input logic [WRW-1:0] wr_smp_count
);
  assert_enter_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_mode) |-> ((32'($past(wr_q_occ)) >= 32'(HI_THR)) ||
                           ($past(drain_req) && ($past(wr_q_occ) != '0))));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (write_mode && !wr_burst) |=> write_mode);

  assert_exit_on_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_mode) |-> $past(wr_burst));

  assert_exit_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_mode) |-> (bus_stall && !rd_grant));

  assert_rd_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_smp_valid == $rose(write_mode));

  assert_wr_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_smp_valid == $fell(write_mode));

  assert_rd_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_smp_valid |-> (32'(rd_smp_count) <= RD_BUF));

  assert_wr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_smp_valid |-> (32'(wr_smp_count) <= WR_BUF));

  logic unused_in;
  assign unused_in = ^{rd_q_occ, rd_burst};
endmodule

bind rw_turn_arbiter rwt_checker #(
  .RD_BUF(RD_BUF), .WR_BUF(WR_BUF), .HI_PCT(HI_PCT)
) chk_i (.*);

// File: tb/rw_turn_arbiter_tb_top.sv
`timescale 1ns/1ps
module rw_turn_arbiter_tb_top;
  localparam int RD_BUF = 16, WR_BUF = 32, HI_PCT = 75, LO_PCT = 50;
  localparam int MIN_WR = 4, TWTR = 3;
  localparam int HI = 24, LO = 16;   // R1 expected watermarks for the defaults
  localparam int RDW = $clog2(RD_BUF + 1), WRW = $clog2(WR_BUF + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RDW-1:0] rd_q_occ = '0;
  logic [WRW-1:0] wr_q_occ = '0;
  logic drain_req = 1'b0, rd_burst = 1'b0, wr_burst = 1'b0;
  logic write_mode, rd_grant, bus_stall, rd_smp_valid, wr_smp_valid;
  logic [RDW-1:0] rd_smp_count;
  logic [WRW-1:0] wr_smp_count;

  always #5 clk = ~clk;

  rw_turn_arbiter #(.RD_BUF(RD_BUF), .WR_BUF(WR_BUF), .HI_PCT(HI_PCT),
    .LO_PCT(LO_PCT), .MIN_WR(MIN_WR), .TWTR(TWTR)) dut_i (.*);

  int vecs = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_wm, m_stall, m_rc, m_wc, m_rsv, m_rsc, m_wsv, m_wsc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wm = 0; m_stall = 0; m_rc = 0; m_wc = 0; m_rsv = 0; m_rsc = 0; m_wsv = 0; m_wsc = 0;
    end else begin
      int rc, wc, occ; bit back;
      rc = m_rc; wc = m_wc; occ = int'(wr_q_occ); back = 0;
      if (rd_burst && rc < RD_BUF) rc++;
      if (wr_burst && wc < WR_BUF) wc++;
      m_rsv = 0; m_wsv = 0;
      if (m_wm == 0) begin
        if (occ >= HI || (drain_req && occ > 0)) begin
          m_wm = 1; m_rsv = 1; m_rsc = rc; rc = 0;
        end
      end else if (wr_burst) begin
        if (occ == 0 || (occ + MIN_WR < LO && !drain_req) ||
            (rd_q_occ != 0 && wc >= MIN_WR)) begin
          m_wm = 0; m_wsv = 1; m_wsc = wc; wc = 0; back = 1;
        end
      end
      if (back) m_stall = TWTR; else if (m_stall > 0) m_stall--;
      m_rc = rc; m_wc = wc;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(write_mode == m_wm[0], "R2 R4 R5 R6 write_mode", write_mode, m_wm);
      check(rd_grant == (m_wm == 0 && m_stall == 0), "R3 R7 rd_grant", rd_grant,
            (m_wm == 0 && m_stall == 0));
      check(bus_stall == (m_stall > 0), "R7 bus_stall", bus_stall, m_stall > 0);
      check(rd_smp_valid == m_rsv[0], "R9 rd_smp_valid", rd_smp_valid, m_rsv);
      check(wr_smp_valid == m_wsv[0], "R9 wr_smp_valid", wr_smp_valid, m_wsv);
      if (m_rsv != 0) check(int'(rd_smp_count) == m_rsc, "R8 R10 rd_smp_count", rd_smp_count, m_rsc);
      if (m_wsv != 0) check(int'(wr_smp_count) == m_wsc, "R8 R10 wr_smp_count", wr_smp_count, m_wsc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL R11 watchdog actual=%0d expected=<150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic step(input int ro, input int wo, input bit dr, input bit rb, input bit wb);
    rd_q_occ = RDW'(ro); wr_q_occ = WRW'(wo); drain_req = dr; rd_burst = rb; wr_burst = wb;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(write_mode == 0 && rd_grant == 1 && bus_stall == 0, "R11 reset mode", write_mode, 0);
    check(rd_smp_valid == 0 && wr_smp_valid == 0, "R11 reset samples", rd_smp_valid, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    // R8: five reads counted in read mode
    for (int i = 0; i < 5; i++) step(3, 10, 0, 1, 0);
    step(3, HI - 1, 0, 0, 0);
    check(write_mode == 0, "R1 R2 below high watermark", write_mode, 0);
    step(3, HI, 0, 0, 0);
    check(write_mode == 1, "R1 R2 at high watermark", write_mode, 1);
    check(rd_smp_valid == 1 && rd_smp_count == 5, "R8 R9 read sample", rd_smp_count, 5);
    step(3, HI, 0, 0, 0);
    check(write_mode == 1 && rd_grant == 0, "R3 idle hold", write_mode, 1);
    check(rd_smp_valid == 0, "R9 single pulse", rd_smp_valid, 0);
    // R6: reads waiting only after MIN_WR writes
    for (int i = 0; i < 3; i++) step(0, 20, 0, 0, 1);
    check(write_mode == 1, "R6 no reads waiting", write_mode, 1);
    step(2, 20, 0, 0, 1);
    check(write_mode == 0 && wr_smp_valid == 1 && wr_smp_count == 4, "R6 R9 exit", wr_smp_count, 4);
    check(bus_stall == 1 && rd_grant == 0, "R7 stall start", bus_stall, 1);
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    check(bus_stall == 1, "R7 stall length", bus_stall, 1);
    step(0, 0, 0, 0, 0);
    check(bus_stall == 0 && rd_grant == 1, "R7 stall end", rd_grant, 1);
    // R2 drain entry, R5 blocked by drain, R4 empty exit
    step(0, 5, 1, 0, 0);
    check(write_mode == 1, "R2 drain entry", write_mode, 1);
    for (int o = 4; o >= 1; o--) step(0, o, 1, 0, 1);
    check(write_mode == 1, "R5 drain blocks hysteresis", write_mode, 1);
    step(0, 0, 1, 0, 1);
    check(write_mode == 0 && wr_smp_count == 5, "R4 empty exit", wr_smp_count, 5);
    repeat (3) step(0, 0, 0, 0, 0);
    // R5 hysteresis boundary
    step(0, HI, 0, 0, 0);
    check(rd_smp_valid == 1 && rd_smp_count == 0, "R9 empty read sample", rd_smp_count, 0);
    step(0, LO - MIN_WR, 0, 0, 1);
    check(write_mode == 1, "R5 boundary equal", write_mode, 1);
    step(0, LO - MIN_WR - 1, 0, 0, 1);
    check(write_mode == 0 && wr_smp_count == 2, "R5 below hysteresis", wr_smp_count, 2);
    repeat (3) step(0, 0, 0, 0, 0);
    // R10 saturation in both directions
    for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 0);
    step(1, HI, 0, 1, 0);
    check(rd_smp_count == RDW'(RD_BUF), "R10 read saturation", rd_smp_count, RD_BUF);
    for (int i = 0; i < 40; i++) step(0, 30, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    check(wr_smp_count == WRW'(WR_BUF), "R10 write saturation", wr_smp_count, WR_BUF);
    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int wo;
      wo = ($urandom_range(0, 3) == 0) ? int'($urandom_range(HI - 2, WR_BUF)) : int'($urandom_range(0, 20));
      step($urandom_range(0, 2), wo, $urandom_range(0, 9) == 0,
           $urandom_range(0, 1), $urandom_range(0, 2) != 0);
    end
    finish_run();
  end
endmodule